// File: doc/BRIEF.md
# APB to Four-Phase Handshake Register Bridge

This block is an APB slave that sits in front of several frequency-locked-loop control ports and turns each APB access into a complete four-phase request/acknowledge exchange on one of those ports. Each port holds four 32-bit registers. Bits [3:2] of the APB address pick the register. The field from bit 4 up to the top of the address picks the port. Only one exchange is in flight at any time. The APB access is held in its access phase until the selected port has acknowledged the request and then released its acknowledge again.

The all-ones port index is reserved. An access to it starts no exchange. It completes in the first access cycle and returns the lock input of every port side by side in the low bits of the read data. An index that is neither a real port nor the reserved one also completes in the first access cycle, with an error response. Acknowledge inputs are brought in through two-flop synchronizers, so the ports may run on a clock unrelated to the APB clock.

Top module: `apb_hs_bridge`

## Requirements
- R1: While presetn is low, every tgt_req bit and pready are low.
- R2: An access with index field paddr[ADDR_W-1:4] below NUM_TGT raises only the tgt_req bit of that index. Every port sees the register number paddr[3:2] on its tgt_sel pair, where register 0 is the read-only status register and registers 1 to 3 are read/write.
- R3: For a write, tgt_we is 1 and tgt_wdata carries pwdata. tgt_we, tgt_sel and tgt_wdata stay stable for as long as a request is high.
- R4: A read through a port returns in prdata the tgt_rdata the port presented while its acknowledge was high, with pslverr low.
- R5: The exchange runs in four steps: raise req, wait for a synchronized ack high, drop req, then wait for a synchronized ack low. pready rises only after that, while every request is low. With a port that answers one cycle after each change of req, pready is high in the ninth cycle after the first access-phase cycle.
- R6: pready is high for exactly one cycle per access, and only while psel and penable are both high.
- R7: An access with the all-ones index completes in its first access-phase cycle with no request raised. prdata[NUM_TGT-1:0] holds tgt_lock, the higher bits are 0, and pslverr is low.
- R8: An access whose index is neither below NUM_TGT nor all ones completes in its first access-phase cycle with pslverr high, prdata zero and no request raised.
- R9: A write to status register 0 goes through the normal exchange and ends without an error.
- R10: At most one tgt_req bit is high at a time, and a new request starts only after the previous exchange has fully returned to idle.
- R11: Each acknowledge passes through two synchronizing flops. A request falls three clock edges after the edge at which its acknowledge rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error response |
| tgt_req | output | NUM_TGT | Per-port request |
| tgt_we | output | NUM_TGT | Per-port write enable |
| tgt_sel | output | 2*NUM_TGT | Per-port register number, two bits each |
| tgt_wdata | output | 32*NUM_TGT | Per-port write data |
| tgt_ack | input | NUM_TGT | Per-port acknowledge, may be asynchronous |
| tgt_rdata | input | 32*NUM_TGT | Per-port read data |
| tgt_lock | input | NUM_TGT | Per-port lock indication |

## Verification
The checker watches several rules on every cycle. At most one request is high at a time. Command signals stay stable while a request is up. A request rises only when that port's acknowledge is low. pready appears only in an access phase and only with all requests low. Accesses to the reserved index and to unknown indices are answered at once with the right data and error flag. Some behaviours only the bench's scenarios can show: read data really coming back from the addressed register, writes to status leaving it unchanged, the exact latency through the synchronizers and the complete exchange, and each port seeing the right number of requests.

// File: rtl/apb_hs_pkg.sv
package apb_hs_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_REL  = 2'd2,
        HS_DONE = 2'd3
    } hs_state_e;

    typedef struct packed {
        hs_state_e   state;
        logic        we;
        logic [1:0]  sel;
        logic [31:0] wdata;
        logic [31:0] rdata;
    } hs_regs_t;

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/hs_addr_decode.sv
module hs_addr_decode #(
    parameter int ADDR_W  = 12,
    parameter int NUM_TGT = 1,
    localparam int IDX_W  = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_TGT-1:0] lock_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_TGT-1:0] onehot_o,
    output logic               is_valid_o,
    output logic               is_lock_o,
    output logic               is_bad_o,
    output logic [31:0]        lock_word_o
);
    assign idx_o      = addr_i[ADDR_W-1:4];
    assign is_lock_o  = &idx_o;
    assign is_valid_o = ({1'b0, idx_o} < (IDX_W+1)'(NUM_TGT));
    assign is_bad_o   = !is_valid_o && !is_lock_o;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_onehot
        assign onehot_o[g] = (idx_o == IDX_W'(g));
    end

    for (genvar b = 0; b < 32; b++) begin : g_lock
        if (b < NUM_TGT) begin : g_used
            assign lock_word_o[b] = lock_i[b];
        end else begin : g_zero
            assign lock_word_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/apb_hs_bridge.sv
module apb_hs_bridge #(
    parameter int ADDR_W  = 12,
    parameter int NUM_TGT = 1
) (
    input  logic                    pclk,
    input  logic                    presetn,
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [31:0]             pwdata,
    output logic [31:0]             prdata,
    output logic                    pready,
    output logic                    pslverr,
    output logic [NUM_TGT-1:0]      tgt_req,
    output logic [NUM_TGT-1:0]      tgt_we,
    output logic [2*NUM_TGT-1:0]    tgt_sel,
    output logic [32*NUM_TGT-1:0]   tgt_wdata,
    input  logic [NUM_TGT-1:0]      tgt_ack,
    input  logic [32*NUM_TGT-1:0]   tgt_rdata,
    input  logic [NUM_TGT-1:0]      tgt_lock
);
    import apb_hs_pkg::*;

    localparam int IDX_W = ADDR_W - 4;

    if (IDX_W < $clog2(NUM_TGT + 1)) begin : g_bad_width
        $error("index field too narrow for NUM_TGT plus the reserved index");
    end
    if (NUM_TGT > 32) begin : g_bad_count
        $error("lock readback holds at most 32 ports");
    end

    hs_regs_t           q, d;
    logic [NUM_TGT-1:0] req_q, req_d;
    logic [IDX_W-1:0]   tgt_q, tgt_d;

    logic [IDX_W-1:0]   dec_idx;
    logic [NUM_TGT-1:0] dec_onehot;
    logic               dec_valid, dec_lock, dec_bad;
    logic [31:0]        lock_word;
    logic [NUM_TGT-1:0] ack_sync;
    logic               ack_sel;
    logic [31:0]        rdata_sel;
    logic               access;

    assign access = psel && penable;

    hs_addr_decode #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT)) dec_i (
        .addr_i      (paddr),
        .lock_i      (tgt_lock),
        .idx_o       (dec_idx),
        .onehot_o    (dec_onehot),
        .is_valid_o  (dec_valid),
        .is_lock_o   (dec_lock),
        .is_bad_o    (dec_bad),
        .lock_word_o (lock_word)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_port
        hs_ack_sync sync_i (
            .clk     (pclk),
            .rst_n   (presetn),
            .async_i (tgt_ack[g]),
            .sync_o  (ack_sync[g])
        );
        assign tgt_we[g]              = q.we;
        assign tgt_sel[2*g +: 2]      = q.sel;
        assign tgt_wdata[32*g +: 32]  = q.wdata;
    end

    assign tgt_req = req_q;

    always_comb begin
        ack_sel   = 1'b0;
        rdata_sel = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (tgt_q == IDX_W'(i)) begin
                ack_sel   = ack_sync[i];
                rdata_sel = tgt_rdata[32*i +: 32];
            end
        end
    end

    always_comb begin
        d     = q;
        req_d = req_q;
        tgt_d = tgt_q;
        case (q.state)
            HS_IDLE: begin
                if (access && dec_valid) begin
                    d.state = HS_REQ;
                    d.we    = pwrite;
                    d.sel   = paddr[3:2];
                    d.wdata = pwdata;
                    req_d   = dec_onehot;
                    tgt_d   = dec_idx;
                end
            end
            HS_REQ: begin
                if (ack_sel) begin
                    d.rdata = rdata_sel;
                    req_d   = '0;
                    d.state = HS_REL;
                end
            end
            HS_REL: begin
                if (!ack_sel) begin
                    d.state = HS_DONE;
                end
            end
            default: begin
                d.state = HS_IDLE;
            end
        endcase
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            q     <= '{state: HS_IDLE, we: 1'b0, sel: 2'b00, wdata: 32'h0, rdata: 32'h0};
            req_q <= '0;
            tgt_q <= '0;
        end else begin
            q     <= d;
            req_q <= req_d;
            tgt_q <= tgt_d;
        end
    end

    always_comb begin
        pready  = 1'b0;
        pslverr = 1'b0;
        prdata  = '0;
        if (q.state == HS_DONE) begin
            pready = 1'b1;
            prdata = q.rdata;
        end else if (q.state == HS_IDLE && access && !dec_valid) begin
            pready  = 1'b1;
            pslverr = dec_bad;
            prdata  = dec_lock ? lock_word : 32'h0;
        end
    end
endmodule

// File: rtl/apb_hs_bridge_chk.sv
module apb_hs_bridge_chk #(
    parameter int ADDR_W  = 12,
    parameter int NUM_TGT = 1,
    localparam int IDX_W  = ADDR_W - 4
) (
    input logic                  pclk,
    input logic                  presetn,
    input logic                  psel,
    input logic                  penable,
    input logic [ADDR_W-1:0]     paddr,
    input logic [31:0]           prdata,
    input logic                  pready,
    input logic                  pslverr,
    input logic [NUM_TGT-1:0]    tgt_req,
    input logic [NUM_TGT-1:0]    tgt_we,
    input logic [2*NUM_TGT-1:0]  tgt_sel,
    input logic [32*NUM_TGT-1:0] tgt_wdata,
    input logic [NUM_TGT-1:0]    tgt_ack,
    input logic [NUM_TGT-1:0]    tgt_lock
);
    logic [IDX_W-1:0] idx;
    logic             idx_lock, idx_bad;
    logic [31:0]      lock_exp;

    assign idx      = paddr[ADDR_W-1:4];
    assign idx_lock = &idx;
    assign idx_bad  = !idx_lock && ({1'b0, idx} >= (IDX_W+1)'(NUM_TGT));
    always_comb begin
        lock_exp = '0;
        lock_exp[NUM_TGT-1:0] = tgt_lock;
    end

    // R10
    req_onehot_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(tgt_req));

    // R3
    cmd_stable_chk: assert property (@(posedge pclk) disable iff (!presetn)
        ((|tgt_req) && $past(|tgt_req)) |->
            ($stable(tgt_we) && $stable(tgt_sel) && $stable(tgt_wdata)));

    // R6
    ready_phase_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready |-> (psel && penable));

    // R5
    ready_idle_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready |-> (tgt_req == '0));

    // R7
    lock_read_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && idx_lock) |-> (pready && !pslverr && prdata == lock_exp));

    // R8
    bad_index_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && idx_bad) |-> (pready && pslverr && prdata == 32'h0));

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_port_chk
        // R5
        req_start_chk: assert property (@(posedge pclk) disable iff (!presetn)
            $rose(tgt_req[g]) |-> !$past(tgt_ack[g]));
    end
endmodule

bind apb_hs_bridge apb_hs_bridge_chk #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT)) chk_i (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .paddr     (paddr),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .tgt_req   (tgt_req),
    .tgt_we    (tgt_we),
    .tgt_sel   (tgt_sel),
    .tgt_wdata (tgt_wdata),
    .tgt_ack   (tgt_ack),
    .tgt_lock  (tgt_lock)
);

// File: tb/apb_hs_bridge_tb_top.sv
module apb_hs_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NUM_TGT    = 3;
    localparam int NVEC       = 11;

    logic                    pclk = 1'b0;
    logic                    presetn = 1'b0;
    logic                    psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]       paddr = '0;
    logic [31:0]             pwdata = '0;
    logic [31:0]             prdata;
    logic                    pready, pslverr;
    logic [NUM_TGT-1:0]      tgt_req, tgt_we;
    logic [2*NUM_TGT-1:0]    tgt_sel;
    logic [32*NUM_TGT-1:0]   tgt_wdata;
    logic [NUM_TGT-1:0]      tgt_ack = '0;
    logic [32*NUM_TGT-1:0]   tgt_rdata;
    logic [NUM_TGT-1:0]      tgt_lock = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    apb_hs_bridge #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT)) dut_i (.*);

    // port models: answer one cycle after each req change, status reads fixed
    logic [31:0] mregs [NUM_TGT][4];
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_model
        always @(posedge pclk or negedge presetn) begin
            if (!presetn) begin
                tgt_ack[g] <= 1'b0;
                mregs[g][0] <= 32'h5A00_0000 | g;
                mregs[g][1] <= '0;
                mregs[g][2] <= '0;
                mregs[g][3] <= '0;
            end else if (tgt_req[g] && !tgt_ack[g]) begin
                tgt_ack[g] <= 1'b1;
                if (tgt_we[g] && tgt_sel[2*g +: 2] != 2'd0)
                    mregs[g][tgt_sel[2*g +: 2]] <= tgt_wdata[32*g +: 32];
            end else if (!tgt_req[g] && tgt_ack[g]) begin
                tgt_ack[g] <= 1'b0;
            end
        end
        assign tgt_rdata[32*g +: 32] = mregs[g][tgt_sel[2*g +: 2]];
    end

    // monitors: edge counter, per-port request count, ack-to-release timing
    int ecnt = 0;
    int rise_cnt [NUM_TGT];
    int t_ack = 0, t_fall = 0;
    logic [NUM_TGT-1:0] req_prev = '0;
    logic ack0_prev = 1'b0;
    always @(posedge pclk) ecnt <= ecnt + 1;
    initial for (int i = 0; i < NUM_TGT; i++) rise_cnt[i] = 0;
    always @(negedge pclk) begin
        for (int i = 0; i < NUM_TGT; i++)
            if (tgt_req[i] && !req_prev[i]) rise_cnt[i] = rise_cnt[i] + 1;
        if (tgt_ack[0] && !ack0_prev) t_ack = ecnt;
        if (!tgt_req[0] && req_prev[0]) t_fall = ecnt;
        req_prev  = tgt_req;
        ack0_prev = tgt_ack[0];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_xfer(input logic wr, input logic [3:0] idx, input logic [1:0] rg,
                            input logic [31:0] wd, output logic [31:0] rd,
                            output logic err, output int cyc);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr;
        paddr = {idx, rg, 2'b00}; pwdata = wd;
        @(negedge pclk);
        penable = 1'b1;
        cyc = 0;
        forever begin
            #1;
            if (pready) break;
            if (cyc > 50) break;
            @(negedge pclk);
            cyc++;
        end
        rd = prdata; err = pslverr;
        @(posedge pclk);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // {write, idx[3:0], reg[1:0], wdata, expected rdata, expected err}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 4'd0, 2'd1, 32'h1111_1111, 32'h0, 1'b0},
        {1'b1, 4'd1, 2'd2, 32'h2222_2222, 32'h0, 1'b0},
        {1'b1, 4'd2, 2'd3, 32'h3333_3333, 32'h0, 1'b0},
        {1'b1, 4'd0, 2'd0, 32'hDEAD_BEEF, 32'h0, 1'b0},
        {1'b0, 4'd0, 2'd1, 32'h0, 32'h1111_1111, 1'b0},
        {1'b0, 4'd1, 2'd2, 32'h0, 32'h2222_2222, 1'b0},
        {1'b0, 4'd2, 2'd3, 32'h0, 32'h3333_3333, 1'b0},
        {1'b0, 4'd0, 2'd0, 32'h0, 32'h5A00_0000, 1'b0},
        {1'b0, 4'd1, 2'd1, 32'h0, 32'h0000_0000, 1'b0},
        {1'b0, 4'd5, 2'd1, 32'h0, 32'h0000_0000, 1'b1},
        {1'b1, 4'd9, 2'd2, 32'hFFFF_0000, 32'h0000_0000, 1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge pclk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic        err;
        int          cyc;
        int          rc [NUM_TGT];

        repeat (3) @(negedge pclk);
        // R1: reset state
        check("R1 req in reset", {29'h0, tgt_req}, 32'h0);
        check("R1 pready in reset", {31'h0, pready}, 32'h0);
        presetn = 1'b1;
        repeat (2) @(negedge pclk);

        for (int v = 0; v < NVEC; v++) begin
            logic [71:0] e;
            e = VEC[v];
            apb_xfer(e[71], e[70:67], e[66:65], e[64:33], rd, err, cyc);
            // R8 unknown index, R9 status write, R4 read path
            check(e[0] ? "R8 error flag" : (e[71] ? "R9 write error flag" : "R4 read error flag"),
                  {31'h0, err}, {31'h0, e[0]});
            if (!e[71] || e[0])
                check(e[0] ? "R8 error data" : "R4 R2 read data", rd, e[32:1]);
            if (e[0])
                check("R8 immediate completion", cyc, 0);
            else
                check("R5 R6 completion cycle", cyc, 9);
        end

        // R10 R2: each port saw exactly its own requests; R7 R8 raised none
        rc = '{4, 3, 2};
        for (int i = 0; i < NUM_TGT; i++)
            check("R10 R2 request count per port", rise_cnt[i], rc[i]);

        // R7: lock readback
        tgt_lock = 3'b101;
        apb_xfer(1'b0, 4'hF, 2'd0, 32'h0, rd, err, cyc);
        check("R7 lock data", rd, 32'h0000_0005);
        check("R7 lock error", {31'h0, err}, 32'h0);
        check("R7 lock latency", cyc, 0);
        tgt_lock = 3'b010;
        apb_xfer(1'b0, 4'hF, 2'd3, 32'h0, rd, err, cyc);
        check("R7 lock data second pattern", rd, 32'h0000_0002);
        for (int i = 0; i < NUM_TGT; i++)
            check("R7 no request from lock read", rise_cnt[i], rc[i]);

        // R3: write data forwarded intact, then read back
        apb_xfer(1'b1, 4'd2, 2'd1, 32'hA5C3_0F96, rd, err, cyc);
        apb_xfer(1'b0, 4'd2, 2'd1, 32'h0, rd, err, cyc);
        check("R3 write data forwarded", rd, 32'hA5C3_0F96);

        // R11: ack to request release through two synchronizer flops
        apb_xfer(1'b0, 4'd0, 2'd2, 32'h0, rd, err, cyc);
        check("R11 ack to release edges", t_fall - t_ack, 3);

        // R6: pready low after completion
        @(negedge pclk);
        check("R6 pready idle", {31'h0, pready}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule